// File: doc/BRIEF.md
# Vector Element Operand Sequencer

This block sits beside the decode stage of a small scalar core and lets that core run vector instructions one element at a time. Each vector register is a group of consecutive scalar registers. The two lowest bits of a fetched instruction word choose, for each source operand separately, whether that operand is a vector or a scalar. For every element step the block produces the register-file indices for both sources and the destination. It also keeps the element counter and tells the core whether more elements follow.

The block also holds the vector-length register and computes the result of the set-length instruction. That result is the requested length clipped to the largest supported length. When the core writes back a set-length instruction, the low bits of that result are loaded into the length register. A length register holding zero stands for the largest length, so an operation always covers at least one element. The core advances its program counter only on a step where the last-element flag is high. The core raises a stall while it waits on the ALU or on memory, and the block then holds its state.

Top module: `vec_elem_seq`

## Requirements
- R1: Instruction bit 0 at 0 makes source 1 a vector operand, and bit 1 at 0 makes source 2 a vector operand. Low bits 11 give a plain scalar instruction, with all three indices equal to their 5-bit fields (rd in bits 11:7, rs1 in bits 19:15, rs2 in bits 24:20).
- R2: The index of a vector operand is the upper 5-VL_WIDTH bits of its register field followed by the element index in the low VL_WIDTH bits. With VL_WIDTH=2, vector n covers scalar registers 4n to 4n+3.
- R3: When either source is a vector, the destination index uses the same grouping with the current element index.
- R4: The index of a scalar operand is its unmodified 5-bit field on every element step.
- R5: A fetched-instruction strobe clears the element index to 0. Each step strobe without stall raises it by one.
- R6: Elements are pending while the instruction is a vector one and element index plus one (modulo 2^VL_WIDTH) differs from the length register. A length register of 0 gives 2^VL_WIDTH elements. last_elem is the inverse of elems_pending.
- R7: A scalar instruction is never pending, so last_elem stays high on it.
- R8: len_result equals min(avl, 2^VL_WIDTH) on VL_WIDTH+1 bits, with every higher bit 0. is_setvl is high when the latched opcode bits 6:2 equal 10101.
- R9: A write-back strobe while is_setvl is high loads len_result[VL_WIDTH-1:0] into the length register. A write-back strobe on any other instruction leaves the register unchanged.
- R10: After reset the length register is 0, the element index is 0, the latched instruction counts as scalar, and nothing is pending.
- R11: A step strobe that arrives while stall is high leaves the element index and all three indices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Strobe: latch instr_word and restart the element count |
| instr_word | input | 32 | Fetched instruction word |
| step | input | 1 | Execute-step strobe from the core |
| stall | input | 1 | Core is waiting; hold the element state |
| wb_valid | input | 1 | Write-back strobe |
| avl | input | 32 | Requested length (source 1 value) |
| rs1_idx | output | 5 | Source 1 register index |
| rs2_idx | output | 5 | Source 2 register index |
| rd_idx | output | 5 | Destination register index |
| elem_idx | output | VL_WIDTH | Current element index |
| elems_pending | output | 1 | More elements follow this one |
| last_elem | output | 1 | This step ends the instruction; the PC may advance |
| is_setvl | output | 1 | The latched instruction is set-length |
| len_result | output | 32 | Clipped set-length result |
| vl_len | output | VL_WIDTH | Current length register |

## Verification
A table applies the four mode combinations with unaligned register fields. It shows whether each operand is decoded on its own bit and whether the destination follows the grouping only when a source is vector. Directed runs walk full-length, two-element and one-element vectors, which tests the zero-means-maximum rule against ordinary length values. A second table feeds set-length requests below, at and above the maximum, including the all-ones value. Further checks show that the length register ignores write-backs of other instructions and that a stalled step changes nothing.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int REG_IDX_W = 5;
  localparam logic [4:0] OPC_SETLEN = 5'b10101;

  typedef struct packed {
    logic                 src1_vec;
    logic                 src2_vec;
    logic [REG_IDX_W-1:0] rs1_f;
    logic [REG_IDX_W-1:0] rs2_f;
    logic [REG_IDX_W-1:0] rd_f;
    logic [4:0]           opc;
  } instr_fields_t;
endpackage

// File: rtl/vseq_instr_latch.sv
module vseq_instr_latch
  import vseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   word,
  output instr_fields_t fields
);
  timeunit 1ns;
  timeprecision 1ps;

  instr_fields_t fields_d;

  always_comb begin
    fields_d = fields;
    if (load) begin
      fields_d.src1_vec = ~word[0];
      fields_d.src2_vec = ~word[1];
      fields_d.rs1_f    = word[19:15];
      fields_d.rs2_f    = word[24:20];
      fields_d.rd_f     = word[11:7];
      fields_d.opc      = word[6:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields <= '0;
    else        fields <= fields_d;
  end

  // R1: operand mode flags come from the inverted low bits
  p_mode_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (fields.src1_vec == ~$past(word[0])) && (fields.src2_vec == ~$past(word[1])));
endmodule

// File: rtl/vseq_elem_ctr.sv
module vseq_elem_ctr #(
  parameter int VL_WIDTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                advance,
  input  logic                is_vec,
  input  logic [VL_WIDTH-1:0] vl,
  output logic [VL_WIDTH-1:0] elem_idx,
  output logic                pending
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [VL_WIDTH-1:0] elem_d;
  logic [VL_WIDTH-1:0] elem_inc;

  assign elem_inc = elem_idx + 1'b1;
  assign pending  = is_vec & (elem_inc != vl);

  always_comb begin
    elem_d = elem_idx;
    if (clear)        elem_d = '0;
    else if (advance) elem_d = elem_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elem_idx <= '0;
    else        elem_idx <= elem_d;
  end

  // R5: a new instruction restarts at element zero
  p_clear_on_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> elem_idx == '0);
  // R11: without clear or advance the counter holds
  p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(elem_idx));
  // R7: scalar work is never pending
  p_scalar_not_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_vec |-> !pending);
endmodule

// File: rtl/vseq_len_unit.sv
module vseq_len_unit #(
  parameter int VL_WIDTH = 2,
  parameter int XLEN     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [XLEN-1:0]     avl,
  output logic [XLEN-1:0]     len_result,
  output logic [VL_WIDTH-1:0] vl
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MAX_VL = 1 << VL_WIDTH;

  logic [VL_WIDTH-1:0] vl_d;

  always_comb begin
    len_result = '0;
    if (avl < XLEN'(MAX_VL)) len_result[VL_WIDTH:0] = avl[VL_WIDTH:0];
    else                     len_result[VL_WIDTH:0] = (VL_WIDTH+1)'(MAX_VL);
  end

  always_comb begin
    vl_d = vl;
    if (load) vl_d = len_result[VL_WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vl <= '0;
    else        vl <= vl_d;
  end

  // R8: the result never exceeds the maximum length
  p_result_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    len_result <= XLEN'(MAX_VL));
  // R9: a set-length write-back loads the clipped value
  p_len_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> vl == $past(len_result[VL_WIDTH-1:0]));
  // R9: other cycles leave the length alone
  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(vl));
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int VL_WIDTH = 2,
  parameter int XLEN     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [31:0]          instr_word,
  input  logic                 step,
  input  logic                 stall,
  input  logic                 wb_valid,
  input  logic [XLEN-1:0]      avl,
  output logic [REG_IDX_W-1:0] rs1_idx,
  output logic [REG_IDX_W-1:0] rs2_idx,
  output logic [REG_IDX_W-1:0] rd_idx,
  output logic [VL_WIDTH-1:0]  elem_idx,
  output logic                 elems_pending,
  output logic                 last_elem,
  output logic                 is_setvl,
  output logic [XLEN-1:0]      len_result,
  output logic [VL_WIDTH-1:0]  vl_len
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_SLOTS = 3;
  localparam int GRP_W     = REG_IDX_W - VL_WIDTH;

  instr_fields_t fields;
  logic          is_vec;
  logic          advance;

  logic [NUM_SLOTS-1:0][REG_IDX_W-1:0] slot_field;
  logic [NUM_SLOTS-1:0]                slot_vec;
  logic [NUM_SLOTS-1:0][REG_IDX_W-1:0] slot_idx;

  vseq_instr_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (instr_valid),
    .word   (instr_word),
    .fields (fields)
  );

  assign is_vec   = fields.src1_vec | fields.src2_vec;
  assign is_setvl = (fields.opc == OPC_SETLEN);
  assign advance  = step & ~stall;

  vseq_elem_ctr #(.VL_WIDTH(VL_WIDTH)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (instr_valid),
    .advance  (advance),
    .is_vec   (is_vec),
    .vl       (vl_len),
    .elem_idx (elem_idx),
    .pending  (elems_pending)
  );

  vseq_len_unit #(.VL_WIDTH(VL_WIDTH), .XLEN(XLEN)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wb_valid & is_setvl),
    .avl        (avl),
    .len_result (len_result),
    .vl         (vl_len)
  );

  // Slot 0: source 1, slot 1: source 2, slot 2: destination
  assign slot_field[0] = fields.rs1_f;
  assign slot_field[1] = fields.rs2_f;
  assign slot_field[2] = fields.rd_f;
  assign slot_vec[0]   = fields.src1_vec;
  assign slot_vec[1]   = fields.src2_vec;
  assign slot_vec[2]   = is_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_idx[s] = slot_vec[s] ? {slot_field[s][REG_IDX_W-1:VL_WIDTH], elem_idx}
                                     : slot_field[s];
  end

  assign rs1_idx   = slot_idx[0];
  assign rs2_idx   = slot_idx[1];
  assign rd_idx    = slot_idx[2];
  assign last_elem = ~elems_pending;

  // R2/R3: a vector destination keeps its group bits across steps
  p_rd_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_vec && !instr_valid) |=> rd_idx[REG_IDX_W-1:VL_WIDTH] == $past(rd_idx[REG_IDX_W-1:GRP_W-GRP_W+VL_WIDTH]));
  // R4: a scalar source does not move while stepping
  p_scalar_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fields.src1_vec && !instr_valid) |=> $stable(rs1_idx));
  // R6: the last-element flag is exclusive with pending
  p_last_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({last_elem, elems_pending}));
endmodule

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int VLW = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid, step, stall, wb_valid;
  logic [31:0] instr_word, avl;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [VLW-1:0] elem_idx, vl_len;
  logic        elems_pending, last_elem, is_setvl;
  logic [31:0] len_result;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vec_elem_seq #(.VL_WIDTH(VLW), .XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .step(step), .stall(stall), .wb_valid(wb_valid), .avl(avl),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx), .elem_idx(elem_idx),
    .elems_pending(elems_pending), .last_elem(last_elem), .is_setvl(is_setvl),
    .len_result(len_result), .vl_len(vl_len)
  );

  function automatic logic [31:0] mk(input logic [4:0] r2, input logic [4:0] r1,
                                     input logic [4:0] rd, input logic [4:0] opc,
                                     input logic [1:0] mode);
    return {7'b0, r2, r1, 3'b0, rd, opc, mode};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic [4:0]  e1, e2, ed;
    logic        pend;
  } mode_vec_t;

  // Expected indices at element 0 with the length register at 0 (four elements)
  localparam mode_vec_t MODE_TBL [4] = '{
    '{mk(5'd9,  5'd5,  5'd13, 5'b01100, 2'b11), 5'd5,  5'd9,  5'd13, 1'b0},
    '{mk(5'd9,  5'd5,  5'd13, 5'b01100, 2'b00), 5'd4,  5'd8,  5'd12, 1'b1},
    '{mk(5'd30, 5'd7,  5'd3,  5'b01100, 2'b01), 5'd7,  5'd28, 5'd0,  1'b1},
    '{mk(5'd6,  5'd31, 5'd22, 5'b01100, 2'b10), 5'd28, 5'd6,  5'd20, 1'b1}
  };

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] r;
  } len_vec_t;

  localparam len_vec_t LEN_TBL [6] = '{
    '{32'd0, 32'd0}, '{32'd1, 32'd1}, '{32'd3, 32'd3},
    '{32'd4, 32'd4}, '{32'd5, 32'd4}, '{32'hFFFF_FFFF, 32'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_instr(input logic [31:0] w);
    instr_word = w; instr_valid = 1'b1;
    tick();
    instr_valid = 1'b0;
  endtask

  task automatic do_step(input logic hold);
    step = 1'b1; stall = hold;
    tick();
    step = 1'b0; stall = 1'b0;
  endtask

  task automatic set_len(input logic [31:0] a);
    load_instr(mk(5'd0, 5'd1, 5'd2, 5'b10101, 2'b11));
    avl = a; wb_valid = 1'b1;
    tick();
    wb_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; step = 1'b0; stall = 1'b0; wb_valid = 1'b0;
    instr_word = '0; avl = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R10: reset state
    chk("R10 vl", 32'(vl_len), 0);
    chk("R10 elem", 32'(elem_idx), 0);
    chk("R10 pending", 32'(elems_pending), 0);

    // R1 R2 R3 R4: mode table at element 0
    for (int i = 0; i < 4; i++) begin
      load_instr(MODE_TBL[i].w);
      chk("R1/R2 rs1", 32'(rs1_idx), 32'(MODE_TBL[i].e1));
      chk("R1/R2 rs2", 32'(rs2_idx), 32'(MODE_TBL[i].e2));
      chk("R3 rd", 32'(rd_idx), 32'(MODE_TBL[i].ed));
      chk("R6/R7 pending", 32'(elems_pending), 32'(MODE_TBL[i].pend));
    end

    // R8: length result table
    for (int i = 0; i < 6; i++) begin
      avl = LEN_TBL[i].a;
      #1;
      chk("R8 len_result", len_result, LEN_TBL[i].r);
    end

    // R5 R6: full walk with length 0 (four elements)
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b00));
    for (int k = 0; k < 4; k++) begin
      chk("R5 elem", 32'(elem_idx), k);
      chk("R2 rs1 walk", 32'(rs1_idx), 4 + k);
      chk("R3 rd walk", 32'(rd_idx), 12 + k);
      chk("R6 pending walk", 32'(elems_pending), (k < 3) ? 1 : 0);
      chk("R6 last walk", 32'(last_elem), (k == 3) ? 1 : 0);
      if (k < 3) do_step(1'b0);
    end

    // R11: stalled step holds everything
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b00));
    do_step(1'b0);
    do_step(1'b1);
    chk("R11 elem", 32'(elem_idx), 1);
    chk("R11 rs1", 32'(rs1_idx), 5);
    chk("R11 rd", 32'(rd_idx), 13);

    // R4: scalar source held across elements
    load_instr(mk(5'd30, 5'd7, 5'd3, 5'b01100, 2'b01));
    do_step(1'b0); do_step(1'b0);
    chk("R4 rs1 scalar", 32'(rs1_idx), 7);
    chk("R2 rs2 vector", 32'(rs2_idx), 30);

    // R8 R9: set length to 2
    set_len(32'd2);
    chk("R8 is_setvl", 32'(is_setvl), 1);
    chk("R9 vl load", 32'(vl_len), 2);
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b00));
    chk("R6 two elem pend0", 32'(elems_pending), 1);
    do_step(1'b0);
    chk("R6 two elem pend1", 32'(elems_pending), 0);
    chk("R3 rd elem1", 32'(rd_idx), 13);

    // R9: write-back of a non-set-length instruction leaves vl alone
    chk("R8 not setvl", 32'(is_setvl), 0);
    avl = 32'd3; wb_valid = 1'b1;
    tick();
    wb_valid = 1'b0;
    chk("R9 vl hold", 32'(vl_len), 2);

    // R6: length one gives a single element
    set_len(32'd1);
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b10));
    chk("R6 one elem", 32'(last_elem), 1);

    // R9: request above maximum stores 0 (meaning full length)
    set_len(32'd77);
    chk("R9 vl max", 32'(vl_len), 0);
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b00));
    do_step(1'b0); do_step(1'b0);
    chk("R6 max pending", 32'(elems_pending), 1);

    // R7: scalar after stepping stays non-pending
    load_instr(mk(5'd9, 5'd5, 5'd13, 5'b01100, 2'b11));
    do_step(1'b0);
    chk("R7 scalar", 32'(elems_pending), 0);
    chk("R1 scalar rd", 32'(rd_idx), 13);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule